// File: doc/BRIEF.md
# Interleaved I/Q Receive Bus Deinterleaver

This block sits behind a receive converter whose 12-bit two's-complement samples arrive on one shared bus, I and Q words taking turns. Next to the data comes a select line whose level marks each word as I or Q. The block captures the select level as a thirteenth bit beside the data. It decides from that level which word is I, pairs each I with the Q that follows it, and presents the two as one aligned sample pair. A one-clock valid pulse marks each pair.

Capture starts when the `arm` input is pulsed. A programmable number of leading words is then thrown away, which lets the interface settle; 8 is the usual setting. The select level that denotes I is an input, so either wiring polarity works. A mode input picks the output format: signed two's complement, or unsigned offset binary, which is made by inverting the sign bit. An I word followed by another I word is a framing slip. The block then resynchronizes on the newer I and pulses an error output.

Top module: `iq_bus_splitter`

## Requirements
- R1: After reset, `out_vld`, `pair_err`, `out_i` and `out_q` are all 0. Until the first `arm` pulse, every input word is ignored and produces no pair and no error.
- R2: `in_word[12]` carries the select level. `in_word[11:0]` carries the 12-bit two's-complement sample.
- R3: An `arm` pulse starts capture. The next `drop_len` words with `in_vld` high are discarded. A `drop_len` of 0 discards none.
- R4: A word whose select bit equals `i_pol` is an I word. A word with the other select level is a Q word.
- R5: When a Q word is accepted while an I word is held, the clock edge that accepts the Q word loads the pair into `out_i`/`out_q`, and `out_vld` is high for exactly one clock after that edge. The outputs keep their values until the next pair.
- R6: A Q word accepted while no I word is held is discarded. It produces no pair and no error.
- R7: An I word accepted while an I word is already held raises `pair_err` for one clock. The new I replaces the held one and is the one paired with the next Q.
- R8: When `ofs_mode` is 1 at the Q word, bit 11 of both output samples is inverted (offset binary). When it is 0, the samples are passed unchanged.
- R9: An `arm` pulse while capturing restarts the discard count and drops any held I. A word presented in the same cycle as `arm` is discarded.
- R10: Cycles with `in_vld` low are ignored. Idle gaps between an I and its Q do not break the pairing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Start or restart capture (one-cycle pulse) |
| drop_len | input | 8 | Number of leading words to discard after `arm` |
| i_pol | input | 1 | Select level that marks an I word |
| ofs_mode | input | 1 | 1: offset binary output, 0: signed output |
| in_vld | input | 1 | Input word present this cycle |
| in_word | input | 13 | Bit 12 is the select level, bits 11:0 are the sample |
| out_i | output | 12 | I sample of the last pair |
| out_q | output | 12 | Q sample of the last pair |
| out_vld | output | 1 | One-clock pulse per completed pair |
| pair_err | output | 1 | One-clock pulse on an I-after-I slip |

## Verification
Strictly alternating I/Q streams are run with both select polarities. This shows whether the polarity input really decides which word is I and which is Q. Out-of-order streams are also applied: a leading Q, two I words in a row, and idle gaps inside a pair. Together they separate correct pairing from a design that simply pairs any two adjacent words. Sign-extreme samples in both output modes confirm that only bit 11 changes. Arming with a nonzero discard count, and re-arming in mid-pair, show whether exactly the right words are dropped and whether a held I is forgotten.

// File: rtl/iq_bus_pkg.sv
package iq_bus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DROP = 2'd1,
    ST_RUN  = 2'd2
  } cap_state_t;
endpackage

// File: rtl/iq_skip_ctrl.sv
module iq_skip_ctrl
  import iq_bus_pkg::*;
#(
  parameter int DROP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [DROP_W-1:0] drop_len,
  input  logic              word_vld,
  output logic              word_acc
);
  cap_state_t        st_q, st_d;
  logic [DROP_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (arm) begin
      cnt_en = 1'b1;
      cnt_d  = drop_len;
      st_d   = (drop_len == '0) ? ST_RUN : ST_DROP;
    end else begin
      case (st_q)
        ST_DROP: begin
          if (word_vld) begin
            cnt_en = 1'b1;
            cnt_d  = cnt_q - 1'b1;
            if (cnt_q == DROP_W'(1)) st_d = ST_RUN;
          end
        end
        ST_RUN:  st_d = ST_RUN;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign word_acc = (st_q == ST_RUN) && word_vld && !arm;

  // R3: each word seen while discarding consumes one count
  a_r3_drop_decrements: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DROP && word_vld && !arm && cnt_q > DROP_W'(1))
      |=> (st_q == ST_DROP && cnt_q == $past(cnt_q) - 1'b1));

  // R3: nothing is accepted outside the running state
  a_r3_no_accept_early: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_RUN) |-> !word_acc);
endmodule

// File: rtl/iq_fmt_lane.sv
module iq_fmt_lane #(
  parameter int DATA_W = 12
) (
  input  logic              ofs_mode,
  input  logic [DATA_W-1:0] raw,
  output logic [DATA_W-1:0] fmt
);
  localparam logic [DATA_W-1:0] SIGN_MASK = {1'b1, {(DATA_W-1){1'b0}}};

  always_comb begin
    fmt = ofs_mode ? (raw ^ SIGN_MASK) : raw;
  end
endmodule

// File: rtl/iq_pair_track.sv
module iq_pair_track #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              acc,
  input  logic              is_i,
  input  logic [DATA_W-1:0] data,
  input  logic              ofs_mode,
  output logic [DATA_W-1:0] out_i,
  output logic [DATA_W-1:0] out_q,
  output logic              out_vld,
  output logic              pair_err
);
  localparam int LANES = 2;

  logic [DATA_W-1:0] hold_q, hold_d;
  logic              hold_v_q, hold_v_d, hold_en;
  logic              vld_d, err_d, emit;
  logic [DATA_W-1:0] lane_raw [LANES];
  logic [DATA_W-1:0] lane_fmt [LANES];

  assign lane_raw[0] = hold_q;
  assign lane_raw[1] = data;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    iq_fmt_lane #(.DATA_W(DATA_W)) fmt_i (
      .ofs_mode (ofs_mode),
      .raw      (lane_raw[g]),
      .fmt      (lane_fmt[g])
    );
  end

  always_comb begin
    hold_d   = hold_q;
    hold_en  = 1'b0;
    hold_v_d = hold_v_q;
    vld_d    = 1'b0;
    err_d    = 1'b0;
    emit     = 1'b0;
    if (clr) begin
      hold_v_d = 1'b0;
    end else if (acc) begin
      if (is_i) begin
        err_d    = hold_v_q;
        hold_en  = 1'b1;
        hold_d   = data;
        hold_v_d = 1'b1;
      end else if (hold_v_q) begin
        emit     = 1'b1;
        vld_d    = 1'b1;
        hold_v_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= '0;
      hold_v_q <= 1'b0;
      out_i    <= '0;
      out_q    <= '0;
      out_vld  <= 1'b0;
      pair_err <= 1'b0;
    end else begin
      hold_v_q <= hold_v_d;
      out_vld  <= vld_d;
      pair_err <= err_d;
      if (hold_en) hold_q <= hold_d;
      if (emit) begin
        out_i <= lane_fmt[0];
        out_q <= lane_fmt[1];
      end
    end
  end

  // R5: a pair comes out only if an I word was held the cycle before
  a_r5_pair_needs_held_i: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(hold_v_q));

  // R5: valid is a single-clock pulse
  a_r5_vld_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |=> !out_vld);

  // R7: a slip and a completed pair never coincide
  a_r7_err_not_with_vld: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_vld && pair_err));

  // R9: a restart drops the held I and suppresses any output
  a_r9_clr_flushes: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!out_vld && !pair_err && !hold_v_q));
endmodule

// File: rtl/iq_bus_splitter.sv
module iq_bus_splitter #(
  parameter int DATA_W = 12,
  parameter int DROP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [DROP_W-1:0] drop_len,
  input  logic              i_pol,
  input  logic              ofs_mode,
  input  logic              in_vld,
  input  logic [DATA_W:0]   in_word,
  output logic [DATA_W-1:0] out_i,
  output logic [DATA_W-1:0] out_q,
  output logic              out_vld,
  output logic              pair_err
);
  localparam int SEL_BIT = DATA_W;

  logic              word_acc;
  logic              word_is_i;
  logic [DATA_W-1:0] word_data;

  assign word_is_i = (in_word[SEL_BIT] == i_pol);
  assign word_data = in_word[DATA_W-1:0];

  iq_skip_ctrl #(.DROP_W(DROP_W)) skip_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (arm),
    .drop_len (drop_len),
    .word_vld (in_vld),
    .word_acc (word_acc)
  );

  iq_pair_track #(.DATA_W(DATA_W)) track_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (arm),
    .acc      (word_acc),
    .is_i     (word_is_i),
    .data     (word_data),
    .ofs_mode (ofs_mode),
    .out_i    (out_i),
    .out_q    (out_q),
    .out_vld  (out_vld),
    .pair_err (pair_err)
  );

  // R10: an idle cycle never yields a slip indication
  a_r10_idle_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !pair_err);
endmodule

// File: tb/iq_bus_splitter_tb_top.sv
`timescale 1ns/1ps
module iq_bus_splitter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        arm;
  logic [7:0]  drop_len;
  logic        i_pol;
  logic        ofs_mode;
  logic        in_vld;
  logic [12:0] in_word;
  logic [11:0] out_i, out_q;
  logic        out_vld, pair_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic        s_vld, s_err;
  logic [11:0] s_i, s_q;

  always #10 clk = ~clk;

  iq_bus_splitter dut_i (
    .clk(clk), .rst_n(rst_n), .arm(arm), .drop_len(drop_len),
    .i_pol(i_pol), .ofs_mode(ofs_mode), .in_vld(in_vld), .in_word(in_word),
    .out_i(out_i), .out_q(out_q), .out_vld(out_vld), .pair_err(pair_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic sample();
    s_vld = out_vld; s_err = pair_err; s_i = out_i; s_q = out_q;
  endtask

  // present one word (optionally with arm), then sample after the edge
  task automatic put(input logic sel, input logic [11:0] d, input logic a = 1'b0);
    in_word = {sel, d}; in_vld = 1'b1; arm = a;
    @(negedge clk);
    in_vld = 1'b0; arm = 1'b0;
    sample();
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      sample();
    end
  endtask

  task automatic do_arm(input logic [7:0] n);
    drop_len = n; arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    sample();
  endtask

  task automatic expect_pair(input string tag, input logic [11:0] ei, input logic [11:0] eq);
    chk(s_vld === 1'b1, {tag, " valid"}, s_vld, 1);
    chk(s_i === ei, {tag, " I"}, s_i, ei);
    chk(s_q === eq, {tag, " Q"}, s_q, eq);
  endtask

  task automatic t_reset();
    chk(out_vld === 1'b0 && pair_err === 1'b0, "R1 reset flags", {out_vld, pair_err}, 0);
    chk(out_i === 12'd0 && out_q === 12'd0, "R1 reset data", {out_i, out_q}, 0);
    i_pol = 1'b1;
    put(1'b1, 12'h111);
    put(1'b0, 12'h222);
    put(1'b1, 12'h333);
    put(1'b1, 12'h444);
    chk(s_vld === 1'b0 && out_vld === 1'b0, "R1 unarmed ignore", s_vld, 0);
    idle(1);
    chk(s_err === 1'b0, "R1 unarmed no err", s_err, 0);
  endtask

  task automatic t_drop();
    int seen = 0;
    i_pol = 1'b1; ofs_mode = 1'b0;
    do_arm(8'd8);
    for (int k = 0; k < 4; k++) begin
      put(1'b1, 12'h100 + 12'(k));
      seen += s_vld;
      put(1'b0, 12'h200 + 12'(k));
      seen += s_vld;
    end
    chk(seen == 0, "R3 eight words dropped", seen, 0);
    put(1'b1, 12'h5A5);
    chk(s_vld === 1'b0, "R4 I alone no pair", s_vld, 0);
    put(1'b0, 12'hA5A);
    expect_pair("R2 R4 R5 first pair", 12'h5A5, 12'hA5A);
    idle(1);
    chk(s_vld === 1'b0, "R5 valid one clock", s_vld, 0);
    chk(s_i === 12'h5A5 && s_q === 12'hA5A, "R5 outputs hold", {s_i, s_q}, {12'h5A5, 12'hA5A});
  endtask

  task automatic t_polarity();
    i_pol = 1'b0; ofs_mode = 1'b0;
    do_arm(8'd0);
    put(1'b0, 12'h0F1);
    put(1'b1, 12'h0F2);
    expect_pair("R4 low select is I", 12'h0F1, 12'h0F2);
    i_pol = 1'b1;
  endtask

  task automatic t_offset();
    i_pol = 1'b1;
    do_arm(8'd0);
    ofs_mode = 1'b1;
    put(1'b1, 12'h800);
    put(1'b0, 12'h7FF);
    expect_pair("R8 offset binary", 12'h000, 12'hFFF);
    put(1'b1, 12'h123);
    put(1'b0, 12'hFFF);
    expect_pair("R8 offset mid", 12'h923, 12'h7FF);
    ofs_mode = 1'b0;
    put(1'b1, 12'h800);
    put(1'b0, 12'h7FF);
    expect_pair("R8 signed passthrough", 12'h800, 12'h7FF);
  endtask

  task automatic t_lead_q();
    do_arm(8'd0);
    put(1'b0, 12'h333);
    chk(s_vld === 1'b0 && s_err === 1'b0, "R6 orphan Q discarded", {s_vld, s_err}, 0);
    put(1'b1, 12'h444);
    chk(s_vld === 1'b0, "R6 no pair on I", s_vld, 0);
    put(1'b0, 12'h555);
    expect_pair("R6 pairing after orphan", 12'h444, 12'h555);
  endtask

  task automatic t_double_i();
    do_arm(8'd0);
    put(1'b1, 12'h0AA);
    chk(s_err === 1'b0, "R7 first I no err", s_err, 0);
    put(1'b1, 12'h0BB);
    chk(s_err === 1'b1 && s_vld === 1'b0, "R7 slip pulse", {s_err, s_vld}, 2);
    put(1'b0, 12'h0CC);
    chk(s_err === 1'b0, "R7 err one clock", s_err, 0);
    expect_pair("R7 newer I used", 12'h0BB, 12'h0CC);
  endtask

  task automatic t_gaps();
    do_arm(8'd0);
    put(1'b1, 12'h6E6);
    idle(3);
    chk(s_vld === 1'b0 && s_err === 1'b0, "R10 gap quiet", {s_vld, s_err}, 0);
    put(1'b0, 12'h7E7);
    expect_pair("R10 pair across gap", 12'h6E6, 12'h7E7);
  endtask

  task automatic t_rearm();
    do_arm(8'd0);
    put(1'b1, 12'h111);
    drop_len = 8'd0;
    put(1'b0, 12'h222, 1'b1);
    chk(s_vld === 1'b0, "R9 word with arm dropped", s_vld, 0);
    put(1'b0, 12'h333);
    chk(s_vld === 1'b0, "R9 held I cleared", s_vld, 0);
    put(1'b1, 12'h444);
    drop_len = 8'd2;
    put(1'b0, 12'h555, 1'b1);
    put(1'b1, 12'h666);
    put(1'b0, 12'h777);
    chk(s_vld === 1'b0, "R9 restart drop count", s_vld, 0);
    put(1'b1, 12'h888);
    put(1'b0, 12'h999);
    expect_pair("R9 after restart", 12'h888, 12'h999);
  endtask

  task automatic t_stream();
    int good = 0;
    do_arm(8'd0);
    for (int k = 0; k < 20; k++) begin
      logic [11:0] a, b;
      a = 12'(k * 37 + 5);
      b = 12'(4095 - k * 53);
      put(1'b1, a);
      put(1'b0, b);
      if (s_vld === 1'b1 && s_i === a && s_q === b) good++;
    end
    chk(good == 20, "R5 back-to-back stream", good, 20);
  endtask

  initial begin
    rst_n = 1'b0; arm = 1'b0; drop_len = 8'd8; i_pol = 1'b1; ofs_mode = 1'b0;
    in_vld = 1'b0; in_word = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_drop();
    t_polarity();
    t_offset();
    t_lead_q();
    t_double_i();
    t_gaps();
    t_rearm();
    t_stream();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule